// File: doc/BRIEF.md
# Interleaved Address Slice/Channel Decoder

This block maps a physical system address onto one of four memory ports, addressed as a slice bit and a channel bit, and produces the compacted address that the chosen port sees. The address first has the memory-mapped I/O hole between top-of-low-memory and 4 GiB removed. Then, for each active interleave (slice, channel, or both), one select bit is chosen. A select bit is normally the XOR parity of the address under a configurable hash mask. Inside a power-of-two override window it is a fixed address bit instead. The select bit positions are then squeezed out of the address, so that every port sees a dense address space.

Addresses that do not land in DRAM are flagged: beyond the 39-bit physical limit, at or above top-of-high-memory, or inside the I/O hole. One registered stage sits between request and result. Configuration is taken only while the block is idle, so a request never sees a mix of old and new settings.

Top module: `slice_chan_decoder`

## Requirements
- R1: `outValid` rises exactly one cycle after each cycle with `inValid` high and is low otherwise. Outputs hold their values in cycles without a request. Reset clears every output to zero.
- R2: The not-DRAM flag is set when address bit 39 is set, or the address is at or above `cfgTohm`, or `cfgTolm` <= address < 4 GiB. With the flag set, `outPort` and `outAddr` are zero.
- R3: The contiguous address equals the address when it is below 4 GiB, and otherwise the address minus (4 GiB − `cfgTolm`). With neither interleave enabled, `outAddr` is that contiguous address and `outPort` is 0.
- R4: A hash-selected bit is the XOR parity of the masked address. The mask field's bit i covers address bit i+6. The slice hash uses the raw address and the channel hash uses the contiguous address. When only one interleave is active, its own select position is added to its mask.
- R5: `cfgMode` codes 0,1,2,3 pick slice select positions 10,11,12,12. With both interleaves active, the channel position is one higher; with only the channel active, it uses the table value. With `cfgBypass` set, the positions are 29 (slice) and 30 (channel, or 29 if the channel is alone), and the configured mask fields are ignored.
- R6: The override window spans `cfgOvrBase` through (`cfgOvrBase` | ~`cfgOvrMask`). Inside it, the slice bit is address bit 12. The channel bit is address bit 13 with both interleaves active and bit 12 otherwise. The same positions are the ones removed.
- R7: The override window is disabled when `cfgOvrEn` is low, or the mask is zero, or the mask's set bits are not one run up to bit 39, or the base has a bit set outside the mask.
- R8: `outPort` is {slice bit, channel bit}. The slice bit is 0 when slice interleave is off, and the channel bit is 0 when channel interleave is off.
- R9: Removing position k keeps bits below k and shifts all higher bits down one. The channel position is removed first, then the slice position. Removal is skipped for an inactive interleave.
- R10: Configuration inputs are captured only in a cycle where `inValid` is low and no result is pending. Changes made during back-to-back traffic take effect after the block has been idle for two cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| inAddr | input | ADDR_W | System address |
| cfgTolm | input | ADDR_W | Top of low memory (bottom of I/O hole) |
| cfgTohm | input | ADDR_W | Top of high memory |
| cfgSliceMask | input | HASH_W | Slice hash mask, bit i covers address bit i+6 |
| cfgChanMask | input | HASH_W | Channel hash mask, bit i covers address bit i+6 |
| cfgMode | input | 2 | Select-position table index |
| cfgBypass | input | 1 | Fixed positions 29/30, masks ignored |
| cfgSliceEn | input | 1 | Slice interleave active |
| cfgChanEn | input | 1 | Channel interleave active |
| cfgOvrEn | input | 1 | Override window enable |
| cfgOvrBase | input | ADDR_W | Override window base |
| cfgOvrMask | input | ADDR_W | Override window mask |
| outValid | output | 1 | Result strobe |
| outPort | output | 2 | {slice, channel} port index |
| outAddr | output | ADDR_W | Compacted per-port address |
| outNotDram | output | 1 | Address is not DRAM |

## Verification
A stale or wrongly captured configuration register shows up on the very next result as a wrong port index or a shifted compacted address. It persists for every following request until the next idle load, so streams are checked result by result in the cycle after each request. A wrong select position or removal order shows as an address off by a power of two in bits at or above position 10. Those bits are checked for every random request, and literal values are checked for the hole boundary, the override window and both removal orders.

// File: rtl/slice_chan_pkg.sv
package slice_chan_pkg;
  typedef struct packed {
    logic loadCfg;
    logic loadReq;
  } decStrobe_t;

  function automatic logic [5:0] modePos(input logic [1:0] mode);
    case (mode)
      2'd0: return 6'd10;
      2'd1: return 6'd11;
      default: return 6'd12;
    endcase
  endfunction
endpackage

// File: rtl/slice_chan_ctrl.sv
module slice_chan_ctrl
  import slice_chan_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  output decStrobe_t strobe,
  output logic       outValid
);
  logic validQ;

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

  // idle means neither a new request nor a pending result
  assign strobe.loadCfg = !inValid && !validQ;
  assign strobe.loadReq = inValid;
  assign outValid = validQ;
endmodule

// File: rtl/slice_chan_datapath.sv
module slice_chan_datapath
  import slice_chan_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int HASH_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  decStrobe_t        strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] cfgTolm,
  input  logic [ADDR_W-1:0] cfgTohm,
  input  logic [HASH_W-1:0] cfgSliceMask,
  input  logic [HASH_W-1:0] cfgChanMask,
  input  logic [1:0]        cfgMode,
  input  logic              cfgBypass,
  input  logic              cfgSliceEn,
  input  logic              cfgChanEn,
  input  logic              cfgOvrEn,
  input  logic [ADDR_W-1:0] cfgOvrBase,
  input  logic [ADDR_W-1:0] cfgOvrMask,
  output logic [1:0]        outPort,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outNotDram
);
  localparam int MASK_LSB = 6;
  localparam logic [ADDR_W-1:0] FOUR_G = ADDR_W'(64'h1_0000_0000);

  function automatic logic [ADDR_W-1:0] removeBit(input logic [ADDR_W-1:0] x, input logic [5:0] k);
    logic [ADDR_W-1:0] low;
    low = (ADDR_W'(1) << k) - ADDR_W'(1);
    return ((x >> 1) & ~low) | (x & low);
  endfunction

  // captured configuration
  logic [ADDR_W-1:0] tolmQ, tohmQ, ovrBaseQ, ovrLimitQ;
  logic [HASH_W-1:0] sliceMaskQ, chanMaskQ;
  logic [1:0]        modeQ;
  logic              bypassQ, sliceEnQ, chanEnQ, ovrOkQ;

  logic [ADDR_W-1:0] invMask;
  logic              ovrValid;
  assign invMask  = ~cfgOvrMask;
  assign ovrValid = cfgOvrEn && (cfgOvrMask != '0)
                 && ((invMask & (invMask + ADDR_W'(1))) == '0)
                 && ((cfgOvrBase & invMask) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tolmQ <= '0; tohmQ <= '0; ovrBaseQ <= '0; ovrLimitQ <= '0;
      sliceMaskQ <= '0; chanMaskQ <= '0; modeQ <= '0;
      bypassQ <= 1'b0; sliceEnQ <= 1'b0; chanEnQ <= 1'b0; ovrOkQ <= 1'b0;
    end else if (strobe.loadCfg) begin
      tolmQ <= cfgTolm; tohmQ <= cfgTohm;
      ovrBaseQ <= cfgOvrBase; ovrLimitQ <= cfgOvrBase | invMask;
      sliceMaskQ <= cfgSliceMask; chanMaskQ <= cfgChanMask; modeQ <= cfgMode;
      bypassQ <= cfgBypass; sliceEnQ <= cfgSliceEn; chanEnQ <= cfgChanEn;
      ovrOkQ <= ovrValid;
    end
  end

  logic              notDram, ovrHit, sliceBit, chanBit;
  logic [5:0]        basePos, slicePos, chanPos, ovrChanPos, sliceRm, chanRm;
  logic [ADDR_W-1:0] contig, sliceHash, chanHash, afterChan, compact;

  always_comb begin
    notDram = inAddr[ADDR_W-1] || (inAddr >= tohmQ) || (inAddr >= tolmQ && inAddr < FOUR_G);
    contig  = (inAddr < FOUR_G) ? inAddr : inAddr - (FOUR_G - tolmQ);

    basePos  = modePos(modeQ);
    slicePos = bypassQ ? 6'd29 : basePos;
    if (bypassQ) chanPos = sliceEnQ ? 6'd30 : 6'd29;
    else         chanPos = sliceEnQ ? basePos + 6'd1 : basePos;

    sliceHash = bypassQ ? '0 : (ADDR_W'(sliceMaskQ) << MASK_LSB);
    chanHash  = bypassQ ? '0 : (ADDR_W'(chanMaskQ) << MASK_LSB);
    if (sliceEnQ && !chanEnQ) sliceHash = sliceHash | (ADDR_W'(1) << slicePos);
    if (chanEnQ && !sliceEnQ) chanHash  = chanHash | (ADDR_W'(1) << chanPos);

    ovrHit     = ovrOkQ && (inAddr >= ovrBaseQ) && (inAddr <= ovrLimitQ);
    ovrChanPos = sliceEnQ ? 6'd13 : 6'd12;

    sliceBit = sliceEnQ && (ovrHit ? inAddr[12] : ^(inAddr & sliceHash));
    chanBit  = chanEnQ && (ovrHit ? inAddr[ovrChanPos] : ^(contig & chanHash));
    sliceRm  = ovrHit ? 6'd12 : slicePos;
    chanRm   = ovrHit ? ovrChanPos : chanPos;

    afterChan = chanEnQ ? removeBit(contig, chanRm) : contig;
    compact   = sliceEnQ ? removeBit(afterChan, sliceRm) : afterChan;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outPort <= '0; outAddr <= '0; outNotDram <= 1'b0;
    end else if (strobe.loadReq) begin
      outPort    <= notDram ? 2'b00 : {sliceBit, chanBit};
      outAddr    <= notDram ? '0 : compact;
      outNotDram <= notDram;
    end
  end
endmodule

// File: rtl/slice_chan_decoder.sv
module slice_chan_decoder
  import slice_chan_pkg::*;
#(
  parameter int ADDR_W = 40,
  parameter int HASH_W = 26
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [ADDR_W-1:0] cfgTolm,
  input  logic [ADDR_W-1:0] cfgTohm,
  input  logic [HASH_W-1:0] cfgSliceMask,
  input  logic [HASH_W-1:0] cfgChanMask,
  input  logic [1:0]        cfgMode,
  input  logic              cfgBypass,
  input  logic              cfgSliceEn,
  input  logic              cfgChanEn,
  input  logic              cfgOvrEn,
  input  logic [ADDR_W-1:0] cfgOvrBase,
  input  logic [ADDR_W-1:0] cfgOvrMask,
  output logic              outValid,
  output logic [1:0]        outPort,
  output logic [ADDR_W-1:0] outAddr,
  output logic              outNotDram
);
  decStrobe_t strobe;

  slice_chan_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .strobe(strobe), .outValid(outValid)
  );

  slice_chan_datapath #(.ADDR_W(ADDR_W), .HASH_W(HASH_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(inAddr),
    .cfgTolm(cfgTolm), .cfgTohm(cfgTohm), .cfgSliceMask(cfgSliceMask),
    .cfgChanMask(cfgChanMask), .cfgMode(cfgMode), .cfgBypass(cfgBypass),
    .cfgSliceEn(cfgSliceEn), .cfgChanEn(cfgChanEn), .cfgOvrEn(cfgOvrEn),
    .cfgOvrBase(cfgOvrBase), .cfgOvrMask(cfgOvrMask),
    .outPort(outPort), .outAddr(outAddr), .outNotDram(outNotDram)
  );
endmodule

// File: rtl/slice_chan_checker.sv
module slice_chan_checker #(
  parameter int ADDR_W = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic              outValid,
  input logic [1:0]        outPort,
  input logic [ADDR_W-1:0] outAddr,
  input logic              outNotDram
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outPort) && $stable(outAddr) && $stable(outNotDram)));

  // R2
  notdram_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outNotDram) |-> (outPort == 2'b00 && outAddr == '0));

  // R9
  compact_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> !outAddr[ADDR_W-1]);
endmodule

bind slice_chan_decoder slice_chan_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .outValid(outValid),
  .outPort(outPort), .outAddr(outAddr), .outNotDram(outNotDram)
);

// File: tb/slice_chan_decoder_tb.sv
`timescale 1ns/1ps
module slice_chan_decoder_tb;
  localparam int AW = 40;
  localparam int HW = 26;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [AW-1:0] inAddr = '0;
  logic [AW-1:0] pTolm = '0, pTohm = '0, pOvrBase = '0, pOvrMask = '0;
  logic [HW-1:0] pSliceMask = '0, pChanMask = '0;
  logic [1:0] pMode = '0;
  logic pBypass = 0, pSliceEn = 0, pChanEn = 0, pOvrEn = 0;
  logic outValid, outNotDram;
  logic [1:0] outPort;
  logic [AW-1:0] outAddr;

  // model copy of applied configuration
  logic [AW-1:0] mTolm, mTohm, mOvrBase, mOvrMask;
  logic [HW-1:0] mSliceMask, mChanMask;
  logic [1:0] mMode;
  logic mBypass, mSliceEn, mChanEn, mOvrEn;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  slice_chan_decoder #(.ADDR_W(AW), .HASH_W(HW)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inAddr(inAddr),
    .cfgTolm(pTolm), .cfgTohm(pTohm), .cfgSliceMask(pSliceMask), .cfgChanMask(pChanMask),
    .cfgMode(pMode), .cfgBypass(pBypass), .cfgSliceEn(pSliceEn), .cfgChanEn(pChanEn),
    .cfgOvrEn(pOvrEn), .cfgOvrBase(pOvrBase), .cfgOvrMask(pOvrMask),
    .outValid(outValid), .outPort(outPort), .outAddr(outAddr), .outNotDram(outNotDram)
  );

  function automatic logic parity(input logic [AW-1:0] x, input logic [AW-1:0] m);
    logic p = 1'b0;
    for (int i = 0; i < AW; i++) p = p ^ (x[i] & m[i]);
    return p;
  endfunction

  function automatic logic [AW-1:0] squeeze(input logic [AW-1:0] x, input int k);
    logic [AW-1:0] y;
    for (int i = 0; i < AW; i++) y[i] = (i < k) ? x[i] : ((i < AW-1) ? x[i+1] : 1'b0);
    return y;
  endfunction

  function automatic logic ovrGood();
    int low = -1;
    if (!mOvrEn || mOvrMask == '0) return 1'b0;
    for (int i = AW-1; i >= 0; i--) if (mOvrMask[i]) low = i;
    for (int i = 0; i < AW; i++) if (i >= low && !mOvrMask[i]) return 1'b0;
    for (int i = 0; i < AW; i++) if (mOvrBase[i] && !mOvrMask[i]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic model(input logic [AW-1:0] a, output logic [1:0] p,
                       output logic [AW-1:0] pa, output logic nd);
    logic [AW-1:0] fourG = 40'h1_0000_0000;
    logic [AW-1:0] c, sm, cm, lim;
    int tbl, sp, cp, srm, crm;
    logic hit, s, ch;
    nd = a[39] || (a >= mTohm) || (a >= mTolm && a < fourG);
    c = (a < fourG) ? a : (a - fourG + mTolm);
    tbl = (mMode == 0) ? 10 : (mMode == 1) ? 11 : 12;
    sp = mBypass ? 29 : tbl;
    cp = mBypass ? (mSliceEn ? 30 : 29) : (mSliceEn ? tbl + 1 : tbl);
    sm = '0; cm = '0;
    for (int i = 0; i < HW; i++) begin
      if (!mBypass && mSliceMask[i]) sm[i+6] = 1'b1;
      if (!mBypass && mChanMask[i])  cm[i+6] = 1'b1;
    end
    if (mSliceEn && !mChanEn) sm[sp] = 1'b1;
    if (mChanEn && !mSliceEn) cm[cp] = 1'b1;
    lim = mOvrBase | ~mOvrMask;
    hit = ovrGood() && a >= mOvrBase && a <= lim;
    s = 0; ch = 0; srm = sp; crm = cp;
    if (mSliceEn) s = hit ? a[12] : parity(a, sm);
    if (hit) begin srm = 12; crm = mSliceEn ? 13 : 12; end
    if (mChanEn) ch = hit ? a[crm] : parity(c, cm);
    if (mChanEn) c = squeeze(c, crm);
    if (mSliceEn) c = squeeze(c, srm);
    p = nd ? 2'b00 : {s, ch};
    pa = nd ? '0 : c;
  endtask

  task automatic check(input string tag, input logic [1:0] ep, input logic [AW-1:0] ea, input logic en);
    checks++;
    if (outValid !== 1'b1 || outPort !== ep || outAddr !== ea || outNotDram !== en) begin
      errors++;
      $display("FAIL %s: got v=%0b port=%0d addr=%h nd=%0b, want v=1 port=%0d addr=%h nd=%0b",
               tag, outValid, outPort, outAddr, outNotDram, ep, ea, en);
    end
  endtask

  // drive at a falling edge, check at the next one; inValid left high
  task automatic sendModel(input logic [AW-1:0] a, input string tag);
    logic [1:0] ep; logic [AW-1:0] ea; logic en;
    model(a, ep, ea, en);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    check(tag, ep, ea, en);
  endtask

  task automatic sendLit(input logic [AW-1:0] a, input logic [1:0] ep,
                         input logic [AW-1:0] ea, input logic en, input string tag);
    inValid = 1'b1; inAddr = a;
    @(negedge clk);
    check(tag, ep, ea, en);
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic applyCfg();
    idle(3);
    mTolm = pTolm; mTohm = pTohm; mOvrBase = pOvrBase; mOvrMask = pOvrMask;
    mSliceMask = pSliceMask; mChanMask = pChanMask; mMode = pMode;
    mBypass = pBypass; mSliceEn = pSliceEn; mChanEn = pChanEn; mOvrEn = pOvrEn;
  endtask

  task automatic baseCfg(input logic se, input logic ce, input logic [1:0] md, input logic bp);
    pTolm = 40'hC000_0000; pTohm = 40'h10_0000_0000;
    pSliceMask = '0; pChanMask = '0; pMode = md; pBypass = bp;
    pSliceEn = se; pChanEn = ce; pOvrEn = 0; pOvrBase = '0; pOvrMask = '0;
    applyCfg();
  endtask

  function automatic logic [AW-1:0] rnd40();
    return {8'($urandom), 32'($urandom)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, want completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    checks++;
    if (outValid !== 0 || outPort !== 0 || outAddr !== 0 || outNotDram !== 0) begin
      errors++;
      $display("FAIL R1 reset: got v=%0b port=%0d addr=%h nd=%0b, want all 0",
               outValid, outPort, outAddr, outNotDram);
    end

    // R2 / R3: hole and limits, no interleave
    baseCfg(0, 0, 2'd0, 0);
    sendLit(40'hC000_0000, 2'd0, '0, 1'b1, "R2 at tolm");
    sendLit(40'hBFFF_FFFF, 2'd0, 40'hBFFF_FFFF, 1'b0, "R2 below tolm");
    sendLit(40'h1_0000_0000, 2'd0, 40'hC000_0000, 1'b0, "R3 at 4G");
    sendLit(40'h1_0000_0100, 2'd0, 40'hC000_0100, 1'b0, "R3 above 4G");
    sendLit(40'h10_0000_0000, 2'd0, '0, 1'b1, "R2 at tohm");
    sendLit(40'h80_0000_0000, 2'd0, '0, 1'b1, "R2 bit39");
    idle(1);
    // R1: held output after idle
    checks++;
    if (outValid !== 0 || outNotDram !== 1'b1) begin
      errors++;
      $display("FAIL R1 hold: got v=%0b nd=%0b, want v=0 nd=1", outValid, outNotDram);
    end

    // R5: mode table, slice alone
    baseCfg(1, 0, 2'd0, 0);
    sendLit(40'h400, 2'd2, '0, 1'b0, "R5 mode0 pos10");
    baseCfg(1, 0, 2'd2, 0);
    sendLit(40'h1000, 2'd2, '0, 1'b0, "R5 mode2 pos12");
    baseCfg(1, 0, 2'd3, 0);
    sendLit(40'h1000, 2'd2, '0, 1'b0, "R5 mode3 pos12");
    // R8: channel alone, mode 1
    baseCfg(0, 1, 2'd1, 0);
    sendLit(40'h800, 2'd1, '0, 1'b0, "R8 channel only");
    // R5: bypass ignores masks, slice alone at 29
    pTolm = 40'hC000_0000; pSliceMask = '1; pChanMask = '1;
    pSliceEn = 1; pChanEn = 0; pBypass = 1; applyCfg();
    sendLit(40'h2000_1000, 2'd2, 40'h1000, 1'b0, "R5 bypass pos29");
    // R9: both, masks zero, removal of 11 then 10
    baseCfg(1, 1, 2'd0, 0);
    sendLit(40'h1C00, 2'd0, 40'h400, 1'b0, "R9 remove order");
    // R4: channel hash on contiguous address, mask bit0 covers addr bit 6
    pChanMask = 26'h1; applyCfg();
    sendModel(40'h1_0000_0040, "R4 channel hash contig");
    sendLit(40'h40, 2'd1, 40'h40, 1'b0, "R4 bit6 parity");

    // R6: override window, both interleaves
    pOvrEn = 1; pOvrBase = 40'h1_0000_0000; pOvrMask = 40'hFF_F000_0000; applyCfg();
    sendLit(40'h1_0000_3000, 2'd3, 40'h3000_0000, 1'b0, "R6 override hit");
    sendModel(40'h1_1000_2000, "R6 above window");
    // R7: bad masks disable the window
    pOvrMask = '0; applyCfg();
    sendLit(40'h1_0000_3000, 2'd0, 40'h3000_0C00, 1'b0, "R7 zero mask");
    pOvrMask = 40'hF0_F000_0000; applyCfg();
    sendModel(40'h1_0000_3000, "R7 gap mask");
    pOvrMask = 40'hFF_F000_0000; pOvrBase = 40'h1_0000_1000; applyCfg();
    sendModel(40'h1_0000_3000, "R7 misaligned base");

    // R10: config change during traffic is not taken
    pOvrBase = 40'h1_0000_0000; applyCfg();
    sendModel(40'h1_0000_3000, "R10 before change");
    pSliceEn = 0; pChanEn = 0; pOvrEn = 0;
    for (int i = 0; i < 4; i++) sendModel(40'h1_0000_3000 + 40'(i * 4096), "R10 busy ignore");
    applyCfg();
    sendLit(40'h1_0000_3000, 2'd0, 40'hC000_3000, 1'b0, "R10 after idle");

    // random configurations and streams
    for (int c = 0; c < 12; c++) begin
      int k;
      pTolm = 40'h8000_0000 + ({8'h0, 32'($urandom)} & 40'h7FF0_0000);
      pTohm = 40'h1_0010_0000 + (rnd40() & 40'h3F_FFF0_0000);
      pSliceMask = HW'($urandom); pChanMask = HW'($urandom);
      pMode = 2'($urandom); pBypass = ($urandom % 4) == 0;
      pSliceEn = 1'($urandom); pChanEn = 1'($urandom); pOvrEn = 1'($urandom);
      k = 12 + int'($urandom % 20);
      pOvrMask = ~((40'h1 << k) - 40'h1);
      if ($urandom % 5 == 0) pOvrMask = pOvrMask ^ (40'h1 << (k + 2));
      pOvrBase = rnd40() & pOvrMask & 40'h0F_FFFF_FFFF;
      applyCfg();
      for (int n = 0; n < 40; n++) begin
        logic [AW-1:0] a;
        case ($urandom % 4)
          0: a = rnd40();
          1: a = {8'h0, 32'($urandom)} % mTolm;
          2: a = 40'h1_0000_0000 + (rnd40() % (mTohm - 40'h1_0000_0000));
          default: a = mOvrBase + (rnd40() & ~mOvrMask);
        endcase
        sendModel(a, "R4,R5,R6,R8,R9 random");
      end
    end
    idle(2);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule